// File: doc/BRIEF.md
# Two-Way Instruction Fetch Cache

This block sits between a processor's instruction fetch port and an external memory port. It accepts 24-bit byte addresses one at a time over a valid/ready handshake and returns one 32-bit instruction word for each accepted fetch. It has 512 sets. Each set holds two lines, one in each of two ways, and each line is four words long.

On a miss the block asks external memory for the whole aligned four-word block. The words arrive in ascending order and are written into the victim line. The requested word goes to the processor in the cycle after it arrives, even if the rest of the line is still loading. The line only becomes valid once its last word has been written.

Three control inputs change how fetches are handled:
- **Enable.** When the cache is disabled, fetches bypass it and become single-word reads.
- **Freeze.** While frozen, the cache contents stay fixed.
- **Flush.** A one-cycle pulse starts an invalidation walk over all sets. A busy flag stays high until the walk ends.

Top module: `fetch_cache`

## Requirements
- R1: A fetch address splits into tag = bits 23..13, set = bits 12..4, word-in-line = bits 3..2. Bits 1..0 never change which word is returned.
- R2: A hit needs a matching tag and a set valid bit in one way. A hit returns the stored word one cycle after the accepting edge, with no external request.
- R3: A miss with the cache enabled raises `memReq` for exactly one cycle. During that cycle `memBurst`=1 and `memAddr` is the line base, with bits 3..0 zero. The block then takes four response beats for words 0, 1, 2 and 3 in that order.
- R4: On a miss, the requested word is delivered in the cycle after the beat that carries it. Word k is delivered after k+1 beats, before the line finishes loading.
- R5: Tag and valid are committed only on the fourth beat. After the fill, every word of the line hits.
- R6: Each set has one replacement bit that names the victim way. A hit or a fill points the bit at the other way, so the line used least recently is evicted.
- R7: With `cacheEn`=0 the arrays are not consulted. A fetch becomes one request with `memBurst`=0 and `memAddr` equal to the fetch address, and the single returned beat goes straight to the processor. A line held in the cache still causes an external read.
- R8: A `flushReq` pulse raises `flushBusy` from the next cycle. The block then clears the valid bits of one set per cycle. `flushBusy` stays high for 512+1 cycles, and `fetchReady` is held low while it is high. Lines cached before the flush miss afterwards.
- R9: With `freeze`=1, hits are served. A miss still makes the four-beat burst and delivers the word, but data, tag, valid and replacement state are left unchanged, so repeating the fetch misses again.
- R10: Only one fetch is outstanding. `fetchReady` is low from the cycle after acceptance until the response.
- R11: After reset `fetchReady`=1, `flushBusy`=0, `memReq`=0, `respValid`=0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cacheEn | input | 1 | 1 = lookups enabled, 0 = pass-through single-word reads |
| freeze | input | 1 | 1 = no updates to data, tag, valid or replacement state |
| flushReq | input | 1 | One-cycle pulse that starts invalidation of all lines |
| flushBusy | output | 1 | High while a flush is pending or in progress |
| fetchValid | input | 1 | Fetch request valid |
| fetchReady | output | 1 | Block can accept a fetch |
| fetchAddr | input | 24 | Fetch byte address |
| respValid | output | 1 | One-cycle pulse: `respData` holds the fetched word |
| respData | output | 32 | Fetched instruction word |
| memReq | output | 1 | One-cycle external read request |
| memBurst | output | 1 | 1 = four-word line read, 0 = single word |
| memAddr | output | 24 | External read address |
| memRespValid | input | 1 | External beat valid |
| memRespData | input | 32 | External beat data |

## Verification
Most wrong internal state in this block shows up at the ports on the next fetch to the same set:
- A tag or valid bit committed too early, or never, turns a later hit into an external request, or a miss into a hit with stale data.
- A wrong replacement bit evicts the more recently used line, so a re-fetch of it requests memory one access later than expected.
- A wrong fill index or forwarding condition shows in the response cycle itself, as a wrong word or as a beat count that differs from the word offset plus one.
- Freeze and flush faults only show on the following fetch, as a hit where a miss is required.

// File: rtl/fetch_cache_pkg.sv
package fetch_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_FILL,
    ST_FLUSH
  } fc_state_t;

  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic capture;    // register the accepted fetch address
    logic hitResp;    // return the hit word
    logic touchLru;   // point the replacement bit away from the hit way
    logic missStart;  // latch the victim way
    logic beatWrite;  // write the incoming beat into the victim line
    logic beatResp;   // forward the incoming beat to the processor
    logic commit;     // write tag, set valid, update replacement bit
    logic clearSet;   // invalidate both ways of clearIdx
    logic singleRead; // external access is a pass-through word read
  } fc_strobe_t;

endpackage

// File: rtl/fetch_cache_ctrl.sv
module fetch_cache_ctrl
  import fetch_cache_pkg::*;
#(
  parameter int SET_W = 9,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cacheEn,
  input  logic             freeze,
  input  logic             flushReq,
  input  logic             fetchValid,
  input  logic             hit,
  input  logic [OFF_W-1:0] offset,
  input  logic             memRespValid,
  output logic             fetchReady,
  output logic             flushBusy,
  output logic             memReq,
  output logic             memBurst,
  output fc_strobe_t       strb,
  output logic [OFF_W-1:0] beatIdx,
  output logic [SET_W-1:0] clearIdx
);

  localparam int NSETS = 1 << SET_W;
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NSETS - 1);
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  fc_state_t        state, stateNext;
  logic [OFF_W-1:0] beatQ;
  logic [SET_W-1:0] clrQ;
  logic             flushPend;
  logic             singleQ;
  logic             allocQ;

  assign fetchReady = (state == ST_IDLE) && !flushPend;
  assign flushBusy  = flushPend || (state == ST_FLUSH);
  assign memBurst   = !singleQ;
  assign beatIdx    = beatQ;
  assign clearIdx   = clrQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    memReq    = 1'b0;
    strb.singleRead = singleQ;
    case (state)
      ST_IDLE: begin
        if (flushPend) begin
          stateNext = ST_FLUSH;
        end else if (fetchValid) begin
          strb.capture = 1'b1;
          stateNext    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!cacheEn) begin
          stateNext = ST_REQ;
        end else if (hit) begin
          strb.hitResp  = 1'b1;
          strb.touchLru = !freeze;
          stateNext     = ST_IDLE;
        end else begin
          strb.missStart = 1'b1;
          stateNext      = ST_REQ;
        end
      end
      ST_REQ: begin
        memReq    = 1'b1;
        stateNext = ST_FILL;
      end
      ST_FILL: begin
        if (memRespValid) begin
          if (singleQ) begin
            strb.beatResp = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strb.beatWrite = allocQ;
            strb.beatResp  = (beatQ == offset);
            if (beatQ == LAST_BEAT) begin
              strb.commit = allocQ;
              stateNext   = ST_IDLE;
            end
          end
        end
      end
      ST_FLUSH: begin
        strb.clearSet = 1'b1;
        if (clrQ == LAST_SET) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatQ     <= '0;
      clrQ      <= '0;
      flushPend <= 1'b0;
      singleQ   <= 1'b0;
      allocQ    <= 1'b0;
    end else begin
      state <= stateNext;
      if (flushReq) flushPend <= 1'b1;
      else if (state == ST_IDLE && flushPend) flushPend <= 1'b0;
      if (state == ST_IDLE && flushPend) clrQ <= '0;
      else if (state == ST_FLUSH) clrQ <= clrQ + 1'b1;
      if (state == ST_LOOK) begin
        singleQ <= !cacheEn;
        allocQ  <= !freeze;
      end
      if (state == ST_REQ) beatQ <= '0;
      else if (state == ST_FILL && memRespValid) beatQ <= beatQ + 1'b1;
    end
  end

endmodule

// File: rtl/fetch_cache_dp.sv
module fetch_cache_dp
  import fetch_cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  fc_strobe_t        strb,
  input  logic [OFF_W-1:0]  beatIdx,
  input  logic [SET_W-1:0]  clearIdx,
  input  logic [DATA_W-1:0] memRespData,
  output logic              hit,
  output logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] memAddr,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);

  localparam int TAG_W  = ADDR_W - SET_W - OFF_W - BYTE_W;
  localparam int NSETS  = 1 << SET_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int WAYS   = 2;
  localparam int LINE_LO = OFF_W + BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [TAG_W-1:0]  tagQ;
  logic [SET_W-1:0]  setQ;
  logic [NSETS-1:0]  lruBits;
  logic              victimQ;
  logic [WAYS-1:0]   hitVec;
  logic [DATA_W-1:0] wordVec [WAYS];
  logic              hitWay;

  assign tagQ   = addrQ[ADDR_W-1 -: TAG_W];
  assign setQ   = addrQ[LINE_LO +: SET_W];
  assign offset = addrQ[BYTE_W +: OFF_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strb.capture) addrQ <= fetchAddr;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] dataMem [NSETS*WORDS];
    logic [TAG_W-1:0]  tagMem  [NSETS];
    logic [NSETS-1:0]  lineValid;
    logic              isVictim;

    assign isVictim = (victimQ == 1'(w));

    always_ff @(posedge clk) begin
      if (strb.beatWrite && isVictim) dataMem[{setQ, beatIdx}] <= memRespData;
      if (strb.commit && isVictim) tagMem[setQ] <= tagQ;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineValid <= '0;
      else if (strb.clearSet) lineValid[clearIdx] <= 1'b0;
      else if (strb.commit && isVictim) lineValid[setQ] <= 1'b1;
    end

    assign hitVec[w]  = lineValid[setQ] && (tagMem[setQ] == tagQ);
    assign wordVec[w] = dataMem[{setQ, offset}];
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruBits <= '0;
      victimQ <= 1'b0;
    end else begin
      if (strb.missStart) victimQ <= lruBits[setQ];
      if (strb.touchLru) lruBits[setQ] <= ~hitWay;
      else if (strb.commit) lruBits[setQ] <= ~victimQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= strb.hitResp || strb.beatResp;
      if (strb.hitResp) respData <= wordVec[hitWay];
      else if (strb.beatResp) respData <= memRespData;
    end
  end

  assign memAddr = strb.singleRead ? addrQ
                                   : {addrQ[ADDR_W-1:LINE_LO], {LINE_LO{1'b0}}};

endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
  import fetch_cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              freeze,
  input  logic              flushReq,
  output logic              flushBusy,
  input  logic              fetchValid,
  output logic              fetchReady,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);

  fc_strobe_t       strb;
  logic [OFF_W-1:0] beatIdx;
  logic [SET_W-1:0] clearIdx;
  logic             hit;
  logic [OFF_W-1:0] offset;

  fetch_cache_ctrl #(.SET_W(SET_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .freeze(freeze),
    .flushReq(flushReq), .fetchValid(fetchValid), .hit(hit),
    .offset(offset), .memRespValid(memRespValid), .fetchReady(fetchReady),
    .flushBusy(flushBusy), .memReq(memReq), .memBurst(memBurst),
    .strb(strb), .beatIdx(beatIdx), .clearIdx(clearIdx)
  );

  fetch_cache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W),
    .OFF_W(OFF_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .strb(strb),
    .beatIdx(beatIdx), .clearIdx(clearIdx), .memRespData(memRespData),
    .hit(hit), .offset(offset), .memAddr(memAddr),
    .respValid(respValid), .respData(respData)
  );

endmodule

// File: rtl/fetch_cache_checker.sv
module fetch_cache_checker
  import fetch_cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic              fetchReady,
  input logic              flushReq,
  input logic              flushBusy,
  input logic              memReq,
  input logic              memBurst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRespValid,
  input logic              respValid,
  input fc_strobe_t        strb,
  input logic [OFF_W-1:0]  beatIdx
);

  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  // R10: one fetch in flight
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> !fetchReady);

  // R10: each response is a single-cycle pulse
  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R8: flag rises after the request
  a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> flushBusy);

  // R8: no fetch accepted while the flush is active
  a_r8_flush_stalls: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> !fetchReady);

  // R3: request lasts one cycle
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R3: line reads start on a line boundary
  a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memBurst) |-> (memAddr[OFF_W+BYTE_W-1:0] == '0));

  // R5: tag and valid are written only with the final beat
  a_r5_commit_last_beat: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (memRespValid && beatIdx == LAST_BEAT));

endmodule

bind fetch_cache fetch_cache_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .flushReq(flushReq), .flushBusy(flushBusy), .memReq(memReq),
  .memBurst(memBurst), .memAddr(memAddr), .memRespValid(memRespValid),
  .respValid(respValid), .strb(strb), .beatIdx(beatIdx)
);

// File: tb/fetch_cache_tb.sv
`timescale 1ns/1ps
module fetch_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b0;
  logic        freeze = 1'b0;
  logic        flushReq = 1'b0;
  logic        flushBusy;
  logic        fetchValid = 1'b0;
  logic        fetchReady;
  logic [23:0] fetchAddr = '0;
  logic        respValid;
  logic [31:0] respData;
  logic        memReq;
  logic        memBurst;
  logic [23:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;

  always #2 clk = ~clk;

  fetch_cache u_dut (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .freeze(freeze),
    .flushReq(flushReq), .flushBusy(flushBusy), .fetchValid(fetchValid),
    .fetchReady(fetchReady), .fetchAddr(fetchAddr), .respValid(respValid),
    .respData(respData), .memReq(memReq), .memBurst(memBurst),
    .memAddr(memAddr), .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int respCount = 0;
  int reqCount = 0;
  int cyc = 0;
  int accCyc = 0;
  int beatsTaken = 0;
  int beatBase = 0;
  int latAtResp = 0;
  int beatsAtResp = 0;
  logic        lastBurst = 1'b0;
  logic [23:0] lastAddr = '0;
  logic [31:0] expQ [$];
  string       curReq = "R2";

  function automatic logic [31:0] memWord(input logic [23:0] a);
    return {8'hC3, a[23:2], 2'b01};
  endfunction

  function automatic logic [23:0] mk(input logic [10:0] t, input logic [8:0] s,
                                     input logic [1:0] w, input logic [1:0] b);
    return {t, s, w, b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;
  always @(posedge clk) if (memRespValid) beatsTaken++;

  // External memory model: two idle cycles, then the beats back to back.
  initial begin
    int beatsLeft = 0;
    int waitCnt = 0;
    int nextIdx = 0;
    logic [23:0] base = '0;
    forever begin
      @(negedge clk);
      memRespValid = 1'b0;
      if (rstN && memReq) begin
        reqCount++;
        lastBurst = memBurst;
        lastAddr  = memAddr;
        base      = {memAddr[23:2], 2'b00};
        beatsLeft = memBurst ? 4 : 1;
        nextIdx   = 0;
        waitCnt   = 2;
        beatBase  = beatsTaken;
      end else if (beatsLeft > 0) begin
        if (waitCnt > 0) begin
          waitCnt--;
        end else begin
          memRespData  = memWord(base + 24'(nextIdx * 4));
          memRespValid = 1'b1;
          nextIdx++;
          beatsLeft--;
        end
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      logic [31:0] exp;
      latAtResp   = cyc - accCyc;
      beatsAtResp = beatsTaken - beatBase;
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected response", respData, 32'h0);
      end else begin
        exp = expQ.pop_front();
        check(respData == exp, curReq, "response word", respData, exp);
      end
      respCount++;
    end
  end

  // kind: 0 = hit, 1 = line miss, 2 = pass-through word read
  task automatic fetch(input logic [23:0] a, input int kind, input string req);
    int r0 = reqCount;
    int c0 = respCount;
    curReq = req;
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    while (!fetchReady) @(negedge clk);
    @(negedge clk);
    fetchValid = 1'b0;
    accCyc = cyc;
    expQ.push_back(memWord(a));
    wait (respCount != c0);
    check((reqCount - r0) == (kind == 0 ? 0 : 1), req, "external request count",
          32'(reqCount - r0), (kind == 0 ? 0 : 1));
    if (kind == 0) begin
      check(latAtResp == 1, req, "hit latency", 32'(latAtResp), 32'd1);
    end else begin
      check(lastBurst == (kind == 1), req, "burst flag", 32'(lastBurst), 32'(kind == 1));
      if (kind == 1)
        check(beatsAtResp == int'(a[3:2]) + 1, req, "beats before forward",
              32'(beatsAtResp), 32'(int'(a[3:2]) + 1));
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(fetchReady == 1'b1, "R11", "fetchReady", 32'(fetchReady), 32'd1);
    check(flushBusy == 1'b0, "R11", "flushBusy", 32'(flushBusy), 32'd0);
    check(memReq == 1'b0, "R11", "memReq", 32'(memReq), 32'd0);
    check(respValid == 1'b0, "R11", "respValid", 32'(respValid), 32'd0);

    // R7 disabled: pass-through with the full address
    fetch(mk(11'd1, 9'd5, 2'd2, 2'd3), 2, "R7");
    check(lastAddr == mk(11'd1, 9'd5, 2'd2, 2'd3), "R7", "pass-through address",
          32'(lastAddr), 32'(mk(11'd1, 9'd5, 2'd2, 2'd3)));

    cacheEn = 1'b1;
    // R3/R4: first enabled fetch misses (R11, R7 no allocation), line base address
    fetch(mk(11'd1, 9'd5, 2'd2, 2'd0), 1, "R3");
    check(lastAddr == mk(11'd1, 9'd5, 2'd0, 2'd0), "R3", "line base address",
          32'(lastAddr), 32'(mk(11'd1, 9'd5, 2'd0, 2'd0)));
    // R5: other words of the line now hit; R1: byte bits ignored
    fetch(mk(11'd1, 9'd5, 2'd3, 2'd0), 0, "R5");
    fetch(mk(11'd1, 9'd5, 2'd0, 2'd1), 0, "R1");
    // R1: different set, same tag misses
    fetch(mk(11'd1, 9'd6, 2'd1, 2'd0), 1, "R1");

    // R7: a cached line still goes to memory when disabled
    cacheEn = 1'b0;
    fetch(mk(11'd1, 9'd5, 2'd3, 2'd0), 2, "R7");
    cacheEn = 1'b1;

    // R6 replacement in set 5
    fetch(mk(11'd2, 9'd5, 2'd0, 2'd0), 1, "R4");
    fetch(mk(11'd1, 9'd5, 2'd1, 2'd0), 0, "R6");
    fetch(mk(11'd3, 9'd5, 2'd3, 2'd0), 1, "R6");
    fetch(mk(11'd1, 9'd5, 2'd0, 2'd0), 0, "R6");
    fetch(mk(11'd2, 9'd5, 2'd1, 2'd0), 1, "R6");

    // R9 freeze
    freeze = 1'b1;
    fetch(mk(11'd1, 9'd5, 2'd2, 2'd0), 0, "R9");
    fetch(mk(11'd7, 9'd9, 2'd1, 2'd0), 1, "R9");
    fetch(mk(11'd7, 9'd9, 2'd1, 2'd0), 1, "R9");
    freeze = 1'b0;

    // R8 flush
    @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    check(flushBusy == 1'b1, "R8", "flushBusy after request", 32'(flushBusy), 32'd1);
    check(fetchReady == 1'b0, "R8", "fetchReady during flush", 32'(fetchReady), 32'd0);
    cnt = 1;
    while (flushBusy) begin
      @(negedge clk);
      if (flushBusy) cnt++;
    end
    check(cnt == 513, "R8", "busy cycles", 32'(cnt), 32'd513);
    fetch(mk(11'd1, 9'd5, 2'd0, 2'd0), 1, "R8");
    fetch(mk(11'd1, 9'd5, 2'd0, 2'd0), 0, "R2");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "leftover expected items", 32'(expQ.size()), 32'd0);
    summary();
    $finish;
  end

endmodule